// File: doc/BRIEF.md
# Atomic Lock Memory

A small word-addressed memory shared by several requester ports. Besides plain loads and stores, each port can issue two indivisible read-modify-write operations: test-and-set, which hands back the current word and leaves a 1 behind, and fetch-and-add, which hands back the current word and stores it plus a two's-complement increment. Software builds spin locks from the first (release is a plain store of 0) and counting semaphores from the second.

Requests from all ports go to a round-robin arbiter. The arbiter grants one port, and that port's transaction completes its read and its write before any other port is granted. A plain load followed by a separate store is not atomic: another port can be served between the two. A test-and-set or fetch-and-add is atomic, because its read and its write belong to one locked two-cycle slot. Every operation returns the value the word held before the operation, on a per-port response strobe.

Top module: `atomic_lock_mem`

## Requirements
- R1: While reset is high and in the cycle after it, every `rsp_valid` bit is 0 and no `req_ready` bit is high unless its port is requesting. Memory starts with all words 0.
- R2: At most one `req_ready` bit is high in any cycle, and only for a port whose `req_valid` is high. The accepted request is the one present in that cycle.
- R3: A load (op code 0) returns the addressed word and leaves memory unchanged, so repeated loads return the same value.
- R4: A store (op code 1) writes `req_wdata` to the word and returns the previous value.
- R5: A test-and-set (op code 2) returns the previous value and leaves the word at 1. A free word (0) is therefore acquired, and a busy word (1) stays 1.
- R6: A fetch-and-add (op code 3) returns the previous value and stores the previous value plus `req_wdata`, read as a two's-complement increment, modulo 2^DW.
- R7: A granted transaction occupies two cycles. In the cycle after any grant, no port is ready, so no access comes between the read and the write of an atomic operation. When several ports test-and-set a free word in the same cycle, exactly one of them reads 0.
- R8: Grants rotate round-robin. After port g is granted, the next grant goes to the first requesting port in the order g+1, g+2, ... (modulo the port count). Port 0 has first priority after reset.
- R9: If a port is ready in cycle t, then `rsp_valid` for that port alone is high for one cycle in cycle t+2, and that port's `rsp_data` carries the old value.
- R10: A requesting port that is not granted sees `req_ready` low. It keeps its request up and is served in a later round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Per-port request present |
| req_op | input | 2*NPORT | Per-port op: 0 load, 1 store, 2 test-and-set, 3 fetch-and-add |
| req_addr | input | AW*NPORT | Per-port word address |
| req_wdata | input | DW*NPORT | Per-port store data or increment |
| req_ready | output | NPORT | Request accepted this cycle |
| rsp_valid | output | NPORT | Response strobe, one cycle |
| rsp_data | output | DW*NPORT | Per-port old value of the word |

## Verification
The assertions check the cycle-level handshake on every cycle. They cover a single grant at a time, a grant only to a requesting port, the dead cycle after each grant that makes the read-modify-write indivisible, and a response to the same port exactly two cycles after its grant. The memory values cannot be checked from the ports in any single cycle, so only the bench scenarios show them. These cover the old-value returns, the test-and-set result on free and busy words, fetch-and-add wrap with negative increments, loads that leave words unchanged, the single winner when ports contend for one lock, and the rotation order of the grants.

// File: rtl/alm_pkg.sv
package alm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_TAS   = 2'd2,
    OP_FADD  = 2'd3
  } alm_op_e;
endpackage

// File: rtl/alm_rr_arbiter.sv
module alm_rr_arbiter #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          enable,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;
  logic          found;

  // search starts one past the last winner and wraps
  always_comb begin
    gnt     = '0;
    gnt_idx = last_q;
    found   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = int'(last_q) + k;
      if (c >= N) c = c - N;
      if (!found && req[c]) begin
        found   = 1'b1;
        gnt_idx = IW'(c);
        gnt[c]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IW'(N - 1);
    else if (enable && found) last_q <= gnt_idx;
  end
endmodule

// File: rtl/alm_mem.sv
module alm_mem #(
  parameter int AW = 4,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/alm_alu.sv
module alm_alu
  import alm_pkg::*;
#(
  parameter int DW = 8
) (
  input  alm_op_e       op,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] new_val,
  output logic          wr_en
);
  always_comb begin
    new_val = old_val;
    wr_en   = 1'b1;
    case (op)
      OP_LOAD:  wr_en   = 1'b0;
      OP_STORE: new_val = operand;
      OP_TAS:   new_val = DW'(1);
      OP_FADD:  new_val = old_val + operand;
      default:  wr_en   = 1'b0;
    endcase
  end
endmodule

// File: rtl/atomic_lock_mem.sv
module atomic_lock_mem
  import alm_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int AW    = 4,
  parameter int DW    = 8,
  localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    req_valid,
  input  logic [2*NPORT-1:0]  req_op,
  input  logic [AW*NPORT-1:0] req_addr,
  input  logic [DW*NPORT-1:0] req_wdata,
  output logic [NPORT-1:0]    req_ready,
  output logic [NPORT-1:0]    rsp_valid,
  output logic [DW*NPORT-1:0] rsp_data
);
  logic             busy_q;
  logic [NPORT-1:0] gnt;
  logic [IW-1:0]    sel_idx;
  logic [IW-1:0]    cur_port_q;
  alm_op_e          cur_op_q;
  logic [AW-1:0]    cur_addr_q;
  logic [DW-1:0]    cur_wdata_q;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    rd_data;
  logic [DW-1:0]    new_val;
  logic             alu_we;
  logic [DW-1:0]    rsp_q [NPORT];

  alm_rr_arbiter #(.N(NPORT), .IW(IW)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req_valid),
    .enable  (!busy_q),
    .gnt     (gnt),
    .gnt_idx (sel_idx)
  );

  assign req_ready = busy_q ? '0 : gnt;
  assign sel_addr  = req_addr[sel_idx*AW +: AW];

  // read in the grant cycle, write back in the locked second cycle
  alm_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (busy_q && alu_we),
    .waddr (cur_addr_q),
    .wdata (new_val),
    .raddr (sel_addr),
    .rdata (rd_data)
  );

  alm_alu #(.DW(DW)) u_alu (
    .op      (cur_op_q),
    .old_val (rd_data),
    .operand (cur_wdata_q),
    .new_val (new_val),
    .wr_en   (alu_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      rsp_valid   <= '0;
      cur_port_q  <= '0;
      cur_op_q    <= OP_LOAD;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
      for (int i = 0; i < NPORT; i++) rsp_q[i] <= '0;
    end else begin
      rsp_valid <= '0;
      if (busy_q) begin
        busy_q                <= 1'b0;
        rsp_valid[cur_port_q] <= 1'b1;
        rsp_q[cur_port_q]     <= rd_data;
      end else if (|req_valid) begin
        busy_q      <= 1'b1;
        cur_port_q  <= sel_idx;
        cur_op_q    <= alm_op_e'(req_op[sel_idx*2 +: 2]);
        cur_addr_q  <= sel_addr;
        cur_wdata_q <= req_wdata[sel_idx*DW +: DW];
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_rsp
    assign rsp_data[g*DW +: DW] = rsp_q[g];
  end
endmodule

// File: rtl/alm_checker.sv
module alm_checker #(
  parameter int NPORT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] req_valid,
  input logic [NPORT-1:0] req_ready,
  input logic [NPORT-1:0] rsp_valid
);
  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);

  a_r7_locked_slot: assert property (@(posedge clk) disable iff (rst)
    (|req_ready) |=> (req_ready == '0));

  a_r9_single_rsp: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_valid));

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    a_r9_rsp_timing: assert property (@(posedge clk) disable iff (rst)
      req_ready[g] |-> ##2 rsp_valid[g]);
  end
endmodule

bind atomic_lock_mem alm_checker #(.NPORT(NPORT)) u_alm_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/atomic_lock_mem_tb.sv
module atomic_lock_mem_tb;
  localparam int NP = 3;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    req_valid = '0;
  logic [2*NP-1:0]  req_op = '0;
  logic [AW*NP-1:0] req_addr = '0;
  logic [DW*NP-1:0] req_wdata = '0;
  logic [NP-1:0]    req_ready;
  logic [NP-1:0]    rsp_valid;
  logic [DW*NP-1:0] rsp_data;

  int nchk = 0;
  int nfail = 0;
  int ref_mem [DEPTH];
  int last_g = NP - 1;

  always #5 clk = ~clk;

  atomic_lock_mem #(.NPORT(NP), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int next_val(input int op, input int old, input int wd);
    case (op)
      0: return old;
      1: return wd & 255;
      2: return 1;
      default: return (old + wd) & 255;
    endcase
  endfunction

  // one request from one port; returns the old value
  task automatic do_op(input int p, input int op, input int a, input int wd,
                       input string rq, output int got);
    int waits;
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_op[p*2 +: 2] = 2'(op);
    req_addr[p*AW +: AW] = AW'(a);
    req_wdata[p*DW +: DW] = DW'(wd);
    waits = 0;
    forever begin
      #1;
      if (req_ready[p] || waits > 10) break;
      @(negedge clk);
      waits++;
    end
    chk(req_ready[p] == 1'b1, "R2 ready for lone requester", int'(req_ready), 1 << p);
    @(negedge clk);
    req_valid[p] = 1'b0;
    chk(rsp_valid == '0, "R9 no response one cycle after grant", int'(rsp_valid), 0);
    @(negedge clk);
    chk(rsp_valid == NP'(1 << p), "R9 response two cycles after grant", int'(rsp_valid), 1 << p);
    got = int'(rsp_data[p*DW +: DW]);
    chk(got == ref_mem[a], rq, got, ref_mem[a]);
    ref_mem[a] = next_val(op, ref_mem[a], wd);
    last_g = p;
  endtask

  // all ports issue the same op to one address in the same cycle
  task automatic contend(input int op, input int a, input int wbase, input string rq);
    int order [NP];
    int got [NP];
    int k, nrsp;
    bit prev_rdy;
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      req_valid[i] = 1'b1;
      req_op[i*2 +: 2] = 2'(op);
      req_addr[i*AW +: AW] = AW'(a);
      req_wdata[i*DW +: DW] = DW'(wbase + i);
    end
    k = 0; nrsp = 0; prev_rdy = 1'b0;
    for (int cyc = 0; cyc < 6 * NP && nrsp < NP; cyc++) begin
      #1;
      if (prev_rdy)
        chk(req_ready == '0, "R7 no grant inside locked slot", int'(req_ready), 0);
      else if (k < NP)
        chk($countones(req_ready) == 1, "R10 one of the waiting ports granted", int'(req_ready), 1);
      prev_rdy = |req_ready;
      for (int i = 0; i < NP; i++)
        if (req_ready[i] && k < NP) begin order[k] = i; k++; end
      @(negedge clk);
      for (int i = 0; i < NP; i++)
        if (prev_rdy && req_ready[i]) req_valid[i] = 1'b0;
      for (int i = 0; i < NP; i++)
        if (rsp_valid[i]) begin got[i] = int'(rsp_data[i*DW +: DW]); nrsp++; end
    end
    req_valid = '0;
    chk(k == NP, "R10 every contender served", k, NP);
    for (int j = 0; j < k; j++) begin
      int exp_p;
      exp_p = (last_g + 1 + j) % NP;
      chk(order[j] == exp_p, "R8 round-robin grant order", order[j], exp_p);
      chk(got[order[j]] == ref_mem[a], rq, got[order[j]], ref_mem[a]);
      ref_mem[a] = next_val(op, ref_mem[a], wbase + order[j]);
    end
    if (k > 0) last_g = order[k-1];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int v;
    int lone_ok;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == '0, "R1 no response in reset", int'(rsp_valid), 0);
    chk(req_ready == '0, "R1 no ready in reset", int'(req_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == '0, "R1 no response after reset", int'(rsp_valid), 0);
    chk(req_ready == '0, "R1 no ready without request", int'(req_ready), 0);

    // initial contents, then store / load sweep over every word
    for (int a = 0; a < DEPTH; a++) do_op(a % NP, 0, a, 0, "R1 word reads zero", v);
    for (int a = 0; a < DEPTH; a++) begin
      do_op(a % NP, 1, a, a * 29 + 3, "R4 store returns old value", v);
      do_op((a + 1) % NP, 0, a, 0, "R3 load returns stored value", v);
      do_op((a + 2) % NP, 0, a, 0, "R3 load left word unchanged", v);
    end

    // test-and-set on non-zero, busy and free words
    for (int a = 0; a < DEPTH; a++) begin
      do_op(a % NP, 2, a, 0, "R5 tas returns prior value", v);
      do_op((a + 1) % NP, 2, a, 0, "R5 tas on busy word reads 1", v);
      do_op((a + 2) % NP, 1, a, 0, "R4 release store returns 1", v);
      do_op(a % NP, 2, a, 0, "R5 tas on free word reads 0", v);
      do_op((a + 1) % NP, 0, a, 0, "R5 word left at 1", v);
    end

    // fetch-and-add with positive, negative and wrapping increments
    for (int a = 0; a < DEPTH; a++) begin
      do_op(a % NP, 1, a, 250 - a, "R4 store before add", v);
      do_op((a + 1) % NP, 3, a, (a * 53 + 7) & 255, "R6 add returns old value", v);
      do_op((a + 2) % NP, 3, a, 255, "R6 add of minus one", v);
      do_op(a % NP, 0, a, 0, "R6 sum stored modulo 2^DW", v);
    end

    // contention: one lock winner, ordered semaphore counts
    for (int a = 0; a < 4; a++) begin
      do_op(a % NP, 1, a, 0, "R4 free the lock", v);
      contend(2, a, 0, "R7 single tas winner reads 0");
      lone_ok = 0;
      do_op((a + 1) % NP, 0, a, 0, "R5 contended lock left at 1", v);
    end
    for (int a = 4; a < DEPTH; a++) begin
      contend(3, a, 254, "R6 contended adds see serial old values");
      do_op(a % NP, 0, a, 0, "R6 contended sum", v);
    end
    contend(0, 1, 0, "R3 contended loads");
    do_op(0, 0, 1, 0, "R3 contended loads left word", v);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule